// File: doc/BRIEF.md
# ATM Cell Header Translator

This block sits in a switch input port and rewrites the connection identifiers of one cell at a time. Each cell arrives as a byte stream: five header bytes followed by 48 payload bytes. The block checks the header check byte and pulls out the path and circuit identifiers. It then looks the connection up in a small local table and emits a new header. That header carries the outgoing identifiers and a freshly computed check byte, and the payload follows it unchanged. Each emitted cell comes with a 2-bit output port taken from the table.

Two header layouts are supported. In the host-side layout, 4 flow-control bits come before an 8-bit path identifier. In the trunk-side layout, those 4 bits become the top of a 12-bit path identifier. In full mode the lookup key is the path and circuit identifiers together, and both are replaced. In path-only mode the key is the path identifier alone, and the circuit identifier goes through untouched. Cells with a bad check byte, and cells that match no table entry, are read in and thrown away. The table is loaded through a single-cycle write port.

The control is a five-state machine:
- `ST_COLLECT` takes in the header bytes.
- `ST_DECIDE` checks the HEC and does the lookup.
- `ST_SEND_HDR` emits the rewritten header.
- `ST_PASS` streams the payload through.
- `ST_DISCARD` sinks the payload of a dropped cell.

The transitions are:
- COLLECT goes to DECIDE after the fifth header byte.
- DECIDE goes to SEND_HDR on a good HEC with a hit, and to DISCARD on a bad HEC or a miss.
- SEND_HDR goes to PASS after the fifth header byte has been sent.
- PASS and DISCARD return to COLLECT after the 48th payload byte.

Top module: `atm_vc_xlat`

## Requirements
- R1: After reset, `in_ready` is 1, and `out_valid`, `miss_pulse` and `hec_drop_cnt` are all 0.
- R2: The four header bytes are read MSB first as one 32-bit word. In the host layout (`cfg_nni`=0) the word is flow-control[31:28], path[27:20], circuit[19:4], type[3:1], loss-priority[0]. In the trunk layout (`cfg_nni`=1) the path identifier is [31:20] and there is no flow-control field.
- R3: The fifth byte is a CRC-8 of that word, using generator 0x07, initial value 0 and MSB-first order, then XORed with 0x55. The emitted header carries this code recomputed over the rewritten word.
- R4: In full mode (`cfg_path_only`=0), a valid entry matches when both its path key and its circuit key are equal to the cell's. The emitted header carries the entry's new path and circuit values, and `out_port` carries the entry's port. An entry written through `tbl_we` applies to every cell looked up afterwards.
- R5: In path-only mode, only the path key is compared. The path identifier is replaced, and the circuit identifier is emitted unchanged.
- R6: The flow-control, type and loss-priority bits are copied unchanged. In the host layout, only the low 8 bits of the new path value are used.
- R7: A cell whose check byte does not match produces no output. `hec_drop_cnt` rises by exactly one, and `miss_pulse` stays low.
- R8: A cell with a good check byte that matches no valid entry produces no output and raises `miss_pulse` for one cycle. An entry whose valid bit is 0 never matches.
- R9: When several valid entries match, the one with the lowest index is used.
- R10: The 48 payload bytes follow the header unchanged and in order. `out_sop` is 1 only on the first header byte. While `out_valid` is high and `out_ready` is low, the output byte is held.
- R11: The first rewritten header byte appears on `out_valid` at the second clock edge after the fifth input header byte is accepted.
- R12: A byte that arrives at a cell boundary without `in_sop` is discarded and does not start a cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_nni | input | 1 | 1 selects the trunk layout with a 12-bit path identifier |
| cfg_path_only | input | 1 | 1 selects path-only switching |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Input byte accepted when high with in_valid |
| in_data | input | 8 | Input byte |
| in_sop | input | 1 | Marks the first header byte of a cell |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream can take a byte |
| out_data | output | 8 | Output byte |
| out_sop | output | 1 | Marks the first output header byte |
| out_port | output | 2 | Destination port of the cell being emitted |
| miss_pulse | output | 1 | One-cycle flag for a table miss |
| hec_drop_cnt | output | CNT_W | Count of cells dropped for a bad check byte |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W | Entry index to write |
| tbl_valid | input | 1 | Valid bit to store |
| tbl_key_vpi | input | 12 | Path key |
| tbl_key_vci | input | 16 | Circuit key, ignored in path-only mode |
| tbl_new_vpi | input | 12 | Outgoing path identifier |
| tbl_new_vci | input | 16 | Outgoing circuit identifier |
| tbl_port | input | 2 | Outgoing port |

## Verification
Hit cells are sent in host full mode, in trunk full mode and in host path-only mode. Together these separate the field positions, the replacement of the circuit identifier and its pass-through. A cell matching two entries shows the index priority, and an invalid entry with a matching key shows that the valid bit gates the match. A corrupted check byte, an unknown key and a stray byte without a start marker show the drop counter, the miss flag and resynchronisation, each without the others. The same hit cell is then resent under random-looking output backpressure and again after its entry has been rewritten, to test data holding and table updates.

// File: rtl/atm_xlat_pkg.sv
package atm_xlat_pkg;

    localparam int VPI_W         = 12;
    localparam int VCI_W         = 16;
    localparam int PORT_W        = 2;
    localparam int HDR_BYTES     = 5;
    localparam int PAYLOAD_BYTES = 48;
    localparam int WORD_W        = 32;

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_DECIDE,
        ST_SEND_HDR,
        ST_PASS,
        ST_DISCARD
    } xlat_state_e;

    typedef struct packed {
        logic [3:0]       gfc;
        logic [VPI_W-1:0] vpi;
        logic [VCI_W-1:0] vci;
        logic [2:0]       pt;
        logic             clp;
    } hdr_fields_t;

    typedef struct packed {
        logic              vld;
        logic [VPI_W-1:0]  key_vpi;
        logic [VCI_W-1:0]  key_vci;
        logic [VPI_W-1:0]  new_vpi;
        logic [VCI_W-1:0]  new_vci;
        logic [PORT_W-1:0] port;
    } vc_entry_t;

    // CRC-8, generator x^8+x^2+x+1, MSB first, coset 0x55
    function automatic logic [7:0] hec_of(input logic [WORD_W-1:0] word);
        logic [7:0] crc;
        logic       fb;
        crc = 8'h00;
        for (int i = WORD_W - 1; i >= 0; i--) begin
            fb  = crc[7] ^ word[i];
            crc = {crc[6:0], 1'b0};
            if (fb) crc = crc ^ 8'h07;
        end
        return crc ^ 8'h55;
    endfunction

endpackage

// File: rtl/atm_hdr_parse.sv
module atm_hdr_parse
    import atm_xlat_pkg::*;
(
    input  logic [WORD_W-1:0] raw_word,
    input  logic [7:0]        raw_hec,
    input  logic              nni,
    output hdr_fields_t       fields,
    output logic              hec_ok
);

    always_comb begin
        fields.vci = raw_word[19:4];
        fields.pt  = raw_word[3:1];
        fields.clp = raw_word[0];
        if (nni) begin
            fields.gfc = 4'h0;
            fields.vpi = raw_word[31:20];
        end else begin
            fields.gfc = raw_word[31:28];
            fields.vpi = {4'h0, raw_word[27:20]};
        end
        hec_ok = (hec_of(raw_word) == raw_hec);
    end

endmodule

// File: rtl/atm_hdr_build.sv
module atm_hdr_build
    import atm_xlat_pkg::*;
(
    input  hdr_fields_t                fields,
    input  logic                       nni,
    output logic [HDR_BYTES*8-1:0]     hdr_bytes
);

    logic [WORD_W-1:0] word;

    always_comb begin
        if (nni) word = {fields.vpi, fields.vci, fields.pt, fields.clp};
        else     word = {fields.gfc, fields.vpi[7:0], fields.vci, fields.pt, fields.clp};
        hdr_bytes = {word, hec_of(word)};
    end

endmodule

// File: rtl/atm_vc_table.sv
module atm_vc_table
    import atm_xlat_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  vc_entry_t        wr_entry,
    input  logic [VPI_W-1:0] look_vpi,
    input  logic [VCI_W-1:0] look_vci,
    input  logic             path_only,
    output logic             hit,
    output vc_entry_t        hit_entry
);

    vc_entry_t              entries [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0] match;

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                entries[g] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                entries[g] <= wr_entry;
            end
        end

        assign match[g] = entries[g].vld
                        && entries[g].key_vpi == look_vpi
                        && (path_only || entries[g].key_vci == look_vci);
    end

    // lowest index wins: scan downward so the last assignment is the lowest match
    always_comb begin
        hit       = |match;
        hit_entry = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_entry = entries[i];
        end
    end

endmodule

// File: rtl/atm_vc_xlat.sv
module atm_vc_xlat
    import atm_xlat_pkg::*;
#(
    parameter  int NUM_ENTRIES = 16,
    parameter  int CNT_W       = 16,
    localparam int IDX_W       = $clog2(NUM_ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_nni,
    input  logic              cfg_path_only,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    input  logic              in_sop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [7:0]        out_data,
    output logic              out_sop,
    output logic [PORT_W-1:0] out_port,
    output logic              miss_pulse,
    output logic [CNT_W-1:0]  hec_drop_cnt,
    input  logic              tbl_we,
    input  logic [IDX_W-1:0]  tbl_idx,
    input  logic              tbl_valid,
    input  logic [VPI_W-1:0]  tbl_key_vpi,
    input  logic [VCI_W-1:0]  tbl_key_vci,
    input  logic [VPI_W-1:0]  tbl_new_vpi,
    input  logic [VCI_W-1:0]  tbl_new_vci,
    input  logic [PORT_W-1:0] tbl_port
);

    localparam int HDR_W    = HDR_BYTES * 8;
    localparam int SEQ_W    = $clog2(PAYLOAD_BYTES);
    localparam int LAST_HDR = HDR_BYTES - 1;
    localparam int LAST_PAY = PAYLOAD_BYTES - 1;

    xlat_state_e       state, state_n;
    logic [SEQ_W-1:0]  seq;
    logic [HDR_W-1:0]  rx_sr;
    logic [HDR_W-1:0]  tx_sr;
    logic [PORT_W-1:0] port_q;
    logic              miss_q;
    logic [CNT_W-1:0]  drop_q;

    hdr_fields_t       rx_fields, tx_fields;
    logic              rx_hec_ok;
    logic              lk_hit;
    vc_entry_t         lk_entry, wr_entry;
    logic [HDR_W-1:0]  tx_built;

    logic hdr_last, pay_last, in_take;

    assign hdr_last = (seq == SEQ_W'(LAST_HDR));
    assign pay_last = (seq == SEQ_W'(LAST_PAY));
    // a new cell may only begin on a byte flagged as start
    assign in_take  = in_valid && (seq != '0 || in_sop);

    atm_hdr_parse u_parse (
        .raw_word (rx_sr[HDR_W-1:8]),
        .raw_hec  (rx_sr[7:0]),
        .nni      (cfg_nni),
        .fields   (rx_fields),
        .hec_ok   (rx_hec_ok)
    );

    always_comb begin
        wr_entry.vld     = tbl_valid;
        wr_entry.key_vpi = tbl_key_vpi;
        wr_entry.key_vci = tbl_key_vci;
        wr_entry.new_vpi = tbl_new_vpi;
        wr_entry.new_vci = tbl_new_vci;
        wr_entry.port    = tbl_port;
    end

    atm_vc_table #(.NUM_ENTRIES(NUM_ENTRIES)) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (tbl_we),
        .wr_idx    (tbl_idx),
        .wr_entry  (wr_entry),
        .look_vpi  (rx_fields.vpi),
        .look_vci  (rx_fields.vci),
        .path_only (cfg_path_only),
        .hit       (lk_hit),
        .hit_entry (lk_entry)
    );

    always_comb begin
        tx_fields     = rx_fields;
        tx_fields.vpi = lk_entry.new_vpi;
        if (!cfg_path_only) tx_fields.vci = lk_entry.new_vci;
    end

    atm_hdr_build u_build (
        .fields    (tx_fields),
        .nni       (cfg_nni),
        .hdr_bytes (tx_built)
    );

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_COLLECT:  if (in_take && hdr_last) state_n = ST_DECIDE;
            ST_DECIDE:   state_n = (rx_hec_ok && lk_hit) ? ST_SEND_HDR : ST_DISCARD;
            ST_SEND_HDR: if (out_ready && hdr_last) state_n = ST_PASS;
            ST_PASS:     if (in_valid && out_ready && pay_last) state_n = ST_COLLECT;
            ST_DISCARD:  if (in_valid && pay_last) state_n = ST_COLLECT;
            default:     state_n = ST_COLLECT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_COLLECT;
        else        state <= state_n;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq    <= '0;
            rx_sr  <= '0;
            tx_sr  <= '0;
            port_q <= '0;
            miss_q <= 1'b0;
            drop_q <= '0;
        end else begin
            miss_q <= 1'b0;
            unique case (state)
                ST_COLLECT: begin
                    if (in_take) begin
                        rx_sr <= {rx_sr[HDR_W-9:0], in_data};
                        seq   <= hdr_last ? '0 : seq + 1'b1;
                    end
                end
                ST_DECIDE: begin
                    seq <= '0;
                    if (!rx_hec_ok) begin
                        drop_q <= drop_q + 1'b1;
                    end else if (!lk_hit) begin
                        miss_q <= 1'b1;
                    end else begin
                        tx_sr  <= tx_built;
                        port_q <= lk_entry.port;
                    end
                end
                ST_SEND_HDR: begin
                    if (out_ready) begin
                        tx_sr <= {tx_sr[HDR_W-9:0], 8'h00};
                        seq   <= hdr_last ? '0 : seq + 1'b1;
                    end
                end
                ST_PASS: begin
                    if (in_valid && out_ready) seq <= pay_last ? '0 : seq + 1'b1;
                end
                ST_DISCARD: begin
                    if (in_valid) seq <= pay_last ? '0 : seq + 1'b1;
                end
                default: seq <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = 8'h00;
        out_sop   = 1'b0;
        unique case (state)
            ST_COLLECT:  in_ready = 1'b1;
            ST_DECIDE:   in_ready = 1'b0;
            ST_SEND_HDR: begin
                out_valid = 1'b1;
                out_data  = tx_sr[HDR_W-1:HDR_W-8];
                out_sop   = (seq == '0);
            end
            ST_PASS: begin
                out_valid = in_valid;
                in_ready  = out_ready;
                out_data  = in_data;
            end
            ST_DISCARD:  in_ready = 1'b1;
            default:     in_ready = 1'b0;
        endcase
    end

    assign out_port     = port_q;
    assign miss_pulse   = miss_q;
    assign hec_drop_cnt = drop_q;

endmodule

// File: rtl/atm_vc_xlat_chk.sv
module atm_vc_xlat_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             out_valid,
    input logic             out_ready,
    input logic [7:0]       out_data,
    input logic             out_sop,
    input logic             miss_pulse,
    input logic [CNT_W-1:0] hec_drop_cnt
);

    // R10: a stalled byte is held
    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sop));

    // R10: the start marker is followed at once by more header, never a second start
    p_sop_once_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_sop |=> out_valid && !out_sop);

    // R8: the miss flag lasts one cycle
    p_miss_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |=> !miss_pulse);

    // R8: a missed cell emits nothing while flagged
    p_miss_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        miss_pulse |-> !out_valid);

    // R7: the drop counter steps by one
    p_drop_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hec_drop_cnt != $past(hec_drop_cnt) |-> hec_drop_cnt == $past(hec_drop_cnt) + 1'b1);

endmodule

bind atm_vc_xlat atm_vc_xlat_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .out_valid    (out_valid),
    .out_ready    (out_ready),
    .out_data     (out_data),
    .out_sop      (out_sop),
    .miss_pulse   (miss_pulse),
    .hec_drop_cnt (hec_drop_cnt)
);

// File: tb/tb_atm_vc_xlat.sv
module tb_atm_vc_xlat;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_nni = 1'b0, cfg_path_only = 1'b0;
    logic        in_valid = 1'b0, in_sop = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_ready;
    logic        out_valid, out_sop, out_ready = 1'b1;
    logic [7:0]  out_data;
    logic [1:0]  out_port;
    logic        miss_pulse;
    logic [15:0] hec_drop_cnt;
    logic        tbl_we = 1'b0, tbl_valid = 1'b0;
    logic [3:0]  tbl_idx = '0;
    logic [11:0] tbl_key_vpi = '0, tbl_new_vpi = '0;
    logic [15:0] tbl_key_vci = '0, tbl_new_vci = '0;
    logic [1:0]  tbl_port = '0;

    int errors = 0, checks = 0, miss_seen = 0, cyc = 0;
    bit bp_mode = 0, done = 0;

    logic [7:0] q_data[$];
    logic       q_sop[$];
    logic [1:0] q_port[$];
    string      q_tag[$];

    always #2 clk = ~clk;

    atm_vc_xlat dut (
        .clk(clk), .rst_n(rst_n), .cfg_nni(cfg_nni), .cfg_path_only(cfg_path_only),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_sop(in_sop),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_sop(out_sop),
        .out_port(out_port), .miss_pulse(miss_pulse), .hec_drop_cnt(hec_drop_cnt),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_valid(tbl_valid),
        .tbl_key_vpi(tbl_key_vpi), .tbl_key_vci(tbl_key_vci),
        .tbl_new_vpi(tbl_new_vpi), .tbl_new_vci(tbl_new_vci), .tbl_port(tbl_port)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // byte-wise CRC-8 (0x07), then coset 0x55
    function automatic logic [7:0] ref_hec(input logic [31:0] w);
        logic [7:0] c = 8'h00;
        for (int b = 3; b >= 0; b--) begin
            c = c ^ w[b*8 +: 8];
            for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
        end
        return c ^ 8'h55;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 out_ready = bp_mode ? ((cyc % 3) != 0) : 1'b1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (miss_pulse) miss_seen++;
        if (rst_n && out_valid && out_ready) begin
            if (q_data.size() == 0) begin
                check(0, "R7/R8 unexpected output byte", out_data, 0);
            end else begin
                automatic logic [7:0] ed = q_data.pop_front();
                automatic logic       es = q_sop.pop_front();
                automatic logic [1:0] ep = q_port.pop_front();
                automatic string      et = q_tag.pop_front();
                check(out_data == ed, {et, " data"}, out_data, ed);
                check(out_sop == es, "R10 sop", out_sop, es);
                check(out_port == ep, "R4 port", out_port, ep);
            end
        end
    end

    task automatic wr(input int idx, input bit v, input logic [11:0] kp, input logic [15:0] kc,
                      input logic [11:0] np, input logic [15:0] nc, input logic [1:0] pt);
        tbl_we = 1; tbl_idx = 4'(idx); tbl_valid = v; tbl_key_vpi = kp; tbl_key_vci = kc;
        tbl_new_vpi = np; tbl_new_vci = nc; tbl_port = pt;
        @(posedge clk); #1 tbl_we = 0;
    endtask

    task automatic send_byte(input logic [7:0] d, input bit sop);
        in_data = d; in_sop = sop; in_valid = 1;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        @(posedge clk); #1 in_valid = 0; in_sop = 0;
    endtask

    // exp_out=0 means the cell must be dropped
    task automatic send_cell(input logic [31:0] raw, input bit bad_hec, input logic [7:0] base,
                             input bit exp_out, input logic [31:0] exp_raw, input logic [1:0] exp_port,
                             input string tag, input bit chk_lat);
        logic [39:0] h = {raw, ref_hec(raw) ^ (bad_hec ? 8'h01 : 8'h00)};
        logic [39:0] eh = {exp_raw, ref_hec(exp_raw)};
        if (exp_out) begin
            for (int i = 0; i < 5; i++) begin
                q_data.push_back(eh[39-8*i -: 8]); q_sop.push_back(i == 0);
                q_port.push_back(exp_port); q_tag.push_back({tag, " R3 header"});
            end
            for (int i = 0; i < 48; i++) begin
                q_data.push_back(base + 8'(i)); q_sop.push_back(1'b0);
                q_port.push_back(exp_port); q_tag.push_back({tag, " R10 payload"});
            end
        end
        for (int i = 0; i < 5; i++) send_byte(h[39-8*i -: 8], i == 0);
        if (chk_lat) begin
            @(negedge clk); check(out_valid == 0, "R11 not yet valid", out_valid, 0);
            @(negedge clk); check(out_valid == 1 && out_sop == 1, "R11 valid on second edge", out_valid, 1);
        end
        for (int i = 0; i < 48; i++) send_byte(base + 8'(i), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(in_ready == 1, "R1 in_ready", in_ready, 1);
        check(out_valid == 0, "R1 out_valid", out_valid, 0);
        check(miss_pulse == 0, "R1 miss", miss_pulse, 0);
        check(hec_drop_cnt == 0, "R1 drop count", hec_drop_cnt, 0);
        @(posedge clk); #1;

        wr(2, 1, 12'h005, 16'h0021, 12'h0A3, 16'h1234, 2'd1);
        wr(5, 1, 12'hABC, 16'h0100, 12'h3C7, 16'hBEEF, 2'd2);
        wr(7, 1, 12'h011, 16'h0000, 12'h022, 16'hFFFF, 2'd3);
        wr(9, 1, 12'h040, 16'h0040, 12'h041, 16'h0000, 2'd0);
        wr(12, 1, 12'h040, 16'h0040, 12'h0FF, 16'h0000, 2'd3);
        wr(14, 0, 12'h050, 16'h0050, 12'h001, 16'h0001, 2'd1);

        // R2 R4 R6 R11: host layout, full mode
        send_cell({4'h6, 8'h05, 16'h0021, 3'b010, 1'b1}, 0, 8'h10, 1,
                  {4'h6, 8'hA3, 16'h1234, 3'b010, 1'b1}, 2'd1, "R4 host full", 1);
        // R2: trunk layout
        cfg_nni = 1;
        send_cell({12'hABC, 16'h0100, 3'b000, 1'b0}, 0, 8'h40, 1,
                  {12'h3C7, 16'hBEEF, 3'b000, 1'b0}, 2'd2, "R2 trunk full", 0);
        cfg_nni = 0;
        // R5: path only
        cfg_path_only = 1;
        send_cell({4'h9, 8'h11, 16'h7777, 3'b100, 1'b0}, 0, 8'h80, 1,
                  {4'h9, 8'h22, 16'h7777, 3'b100, 1'b0}, 2'd3, "R5 path only", 0);
        cfg_path_only = 0;
        // R9: priority
        send_cell({4'h0, 8'h40, 16'h0040, 3'b001, 1'b0}, 0, 8'hA0, 1,
                  {4'h0, 8'h41, 16'h0000, 3'b001, 1'b0}, 2'd0, "R9 lowest index", 0);
        // R7: bad check byte
        send_cell({4'h6, 8'h05, 16'h0021, 3'b010, 1'b1}, 1, 8'h00, 0, 32'h0, 2'd0, "R7", 0);
        repeat (2) @(negedge clk);
        check(hec_drop_cnt == 1, "R7 drop count", hec_drop_cnt, 1);
        check(miss_seen == 0, "R7 no miss flag", miss_seen, 0);
        @(posedge clk); #1;
        // R8: invalid entry, then unknown key
        send_cell({4'h0, 8'h50, 16'h0050, 3'b000, 1'b0}, 0, 8'h00, 0, 32'h0, 2'd0, "R8", 0);
        send_cell({4'h0, 8'h77, 16'h0001, 3'b000, 1'b0}, 0, 8'h00, 0, 32'h0, 2'd0, "R8", 0);
        // R12: stray byte without start marker
        send_byte(8'hEE, 0);
        send_cell({4'h6, 8'h05, 16'h0021, 3'b010, 1'b1}, 0, 8'h20, 1,
                  {4'h6, 8'hA3, 16'h1234, 3'b010, 1'b1}, 2'd1, "R12 resync", 0);
        // R10: backpressure
        bp_mode = 1;
        send_cell({4'h6, 8'h05, 16'h0021, 3'b010, 1'b1}, 0, 8'hC0, 1,
                  {4'h6, 8'hA3, 16'h1234, 3'b010, 1'b1}, 2'd1, "R10 backpressure", 0);
        bp_mode = 0;
        // R4: table rewrite takes effect
        wr(2, 1, 12'h005, 16'h0021, 12'h0B4, 16'h0001, 2'd0);
        send_cell({4'h6, 8'h05, 16'h0021, 3'b010, 1'b1}, 0, 8'h30, 1,
                  {4'h6, 8'hB4, 16'h0001, 3'b010, 1'b1}, 2'd0, "R4 rewritten entry", 0);

        for (int w = 0; w < 2000 && q_data.size() != 0; w++) @(posedge clk);
        repeat (4) @(negedge clk);
        check(q_data.size() == 0, "R10 all expected bytes seen", q_data.size(), 0);
        check(miss_seen == 2, "R8 miss pulses", miss_seen, 2);
        check(hec_drop_cnt == 1, "R7 final drop count", hec_drop_cnt, 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule